// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A clock-enable pulse at sixteen times the bit rate paces it. While hunting, it waits for a high-to-low transition of the line. It confirms the start bit half a bit later and then samples every following bit at the centre of its period. It returns the character right-justified, together with a one-clock valid strobe and parity and framing flags that belong to that strobe.

Static configuration inputs set the following:
- the data length, from five to nine bits;
- the parity rule: none, odd, even, forced one or forced zero;
- the stop length: half, one, one and a half or two bit periods;
- the bit order;
- two inversion options. One inverts the whole line. The other inverts only the data and parity bits.

Configuration must not change while a frame is being received.

Top module: `urx_top`

## Requirements
- R1: While reset is asserted, and after it is released with no frame received, `rx_valid`, `rx_parity_err`, `rx_frame_err` and `rx_data` are all zero.
- R2: With `cfg_msb_first`=0, the first data bit after the start bit is bit 0 of `rx_data`. `cfg_data_bits` selects 5 to 9 data bits (values below 5 act as 5, above 9 as 9), and `rx_data` bits at and above the length read zero.
- R3: With `cfg_msb_first`=1, the first data bit received is the most significant bit of the selected length.
- R4: With `cfg_parity` 1 (odd) or 2 (even), one parity bit follows the data. `rx_parity_err` is 1 when the count of ones over the data and parity bits is not odd (mode 1) or not even (mode 2).
- R5: With `cfg_parity` 3 the parity bit must be 1, and with 4 it must be 0. Otherwise `rx_parity_err` is 1. Code 0 (and 5 to 7) means no parity bit is present.
- R6: With `tick_16x` held high, `rx_valid` rises N clocks after the `rxd` start edge is driven, where N = 20 + 16·(data bits + parity bits) + S. `cfg_stop` selects S: code 0 (half bit) gives S=3, 1 (one bit) gives 7, 2 (one and a half) gives 19, 3 (two bits) gives 23.
- R7: `rx_frame_err` is 1 when any stop-level sample reads low.
- R8: With `cfg_inv_line`=1 the idle level is low and every bit on `rxd` is the complement of the normal frame.
- R9: With `cfg_inv_data`=1 only the data and parity bits are complemented, while the start and stop bits keep normal polarity.
- R10: A low pulse shorter than half a bit is rejected: no frame is produced.
- R11: `rx_valid` is high for exactly one clock per frame, and `rx_data` and the error flags are valid in that cycle.
- R12: While `tick_16x` is low, the receiver does not advance, so no frame is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Clock enable at 16x the bit rate |
| rxd | input | 1 | Serial input line |
| cfg_data_bits | input | 4 | Data length, 5 to 9 |
| cfg_parity | input | 3 | 0 none, 1 odd, 2 even, 3 forced one, 4 forced zero |
| cfg_stop | input | 2 | 0 half, 1 one, 2 one and a half, 3 two bit periods |
| cfg_msb_first | input | 1 | 1 selects most-significant-bit-first order |
| cfg_inv_line | input | 1 | Invert the whole line |
| cfg_inv_data | input | 1 | Invert data and parity bits only |
| rx_data | output | 9 | Received character, right-justified |
| rx_valid | output | 1 | One-clock strobe for a completed frame |
| rx_parity_err | output | 1 | Parity mismatch for the frame in this strobe |
| rx_frame_err | output | 1 | Low stop level for the frame in this strobe |

## Verification
With the tick held high, every result lands at one fixed clock count after the start edge is driven. That count is 20 + 16·(data + parity bits), plus 3, 7, 19 or 23 for the stop length. The offset covers two synchronizer flops and one confirmation edge. A monitor stamps each strobe with a free-running cycle counter, and the bench compares that stamp with the computed count. Data and flags are checked against the same strobe. Rejection cases check that the strobe count does not move over a window long enough for a whole frame.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } state_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_ONE   = 3'd3,
    PAR_ZERO  = 3'd4
  } par_e;

  typedef enum logic [1:0] {
    STOP_HALF    = 2'd0,
    STOP_ONE     = 2'd1,
    STOP_ONEHALF = 2'd2,
    STOP_TWO     = 2'd3
  } stop_e;
endpackage

// File: rtl/urx_line_sync.sv
module urx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic invert,
  output logic line
);
  logic [STAGES-1:0] q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q[0] <= 1'b0;
          else        q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q[g] <= 1'b0;
          else        q[g] <= q[g-1];
      end
    end
  endgenerate

  assign line = q[STAGES-1] ^ invert;
endmodule

// File: rtl/urx_frame_ctrl.sv
module urx_frame_ctrl
  import urx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int CW  = $clog2(2*OVS),
  parameter int LW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          par_en,
  input  stop_e         stop_sel,
  input  logic [LW-1:0] last_idx,
  output state_e        st,
  output logic [CW-1:0] cnt,
  output logic          clr,
  output logic          data_stb,
  output logic          par_stb,
  output logic          stop_stb,
  output logic          done
);
  localparam int MID  = OVS/2 - 1;
  localparam int QTR  = OVS/4 - 1;
  localparam int LAST = OVS - 1;

  state_e        st_n;
  logic [CW-1:0] cnt_n;
  logic [LW-1:0] idx, idx_n;
  logic          prev_hi, prev_n;
  logic [CW-1:0] chk_pt, fin_pt, end_pt;

  // Stop-phase sample, final and exit points per stop length
  always_comb begin
    unique case (stop_sel)
      STOP_HALF:    begin chk_pt = CW'(QTR); fin_pt = CW'(QTR);       end_pt = CW'(MID);       end
      STOP_ONE:     begin chk_pt = CW'(MID); fin_pt = CW'(MID);       end_pt = CW'(MID);       end
      STOP_ONEHALF: begin chk_pt = CW'(MID); fin_pt = CW'(OVS + QTR); end_pt = CW'(OVS + QTR); end
      default:      begin chk_pt = CW'(MID); fin_pt = CW'(OVS + MID); end_pt = CW'(OVS + MID); end
    endcase
  end

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    idx_n    = idx;
    prev_n   = prev_hi;
    clr      = 1'b0;
    data_stb = 1'b0;
    par_stb  = 1'b0;
    stop_stb = 1'b0;
    done     = 1'b0;
    if (tick) begin
      prev_n = line;
      cnt_n  = cnt + 1'b1;
      unique case (st)
        ST_IDLE: begin
          cnt_n = '0;
          if (!line && prev_hi) begin
            st_n = ST_START;
            clr  = 1'b1;
          end
        end
        ST_START: begin
          if (cnt == CW'(MID) && line) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
          end else if (cnt == CW'(LAST)) begin
            st_n  = ST_DATA;
            cnt_n = '0;
            idx_n = '0;
          end
        end
        ST_DATA: begin
          data_stb = (cnt == CW'(MID));
          if (cnt == CW'(LAST)) begin
            cnt_n = '0;
            if (idx == last_idx) st_n = par_en ? ST_PAR : ST_STOP;
            else                 idx_n = idx + 1'b1;
          end
        end
        ST_PAR: begin
          par_stb = (cnt == CW'(MID));
          if (cnt == CW'(LAST)) begin
            st_n  = ST_STOP;
            cnt_n = '0;
          end
        end
        ST_STOP: begin
          stop_stb = (cnt == chk_pt) || (cnt == fin_pt);
          done     = (cnt == fin_pt);
          if (cnt == end_pt) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
          end
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      prev_hi <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      idx     <= idx_n;
      prev_hi <= prev_n;
    end
  end
endmodule

// File: rtl/urx_assembler.sv
module urx_assembler
  import urx_pkg::*;
#(
  parameter int DMAX = 9,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line,
  input  logic            inv_data,
  input  logic            msb_first,
  input  par_e            par_mode,
  input  logic [LW-1:0]   len,
  input  logic            clr,
  input  logic            data_stb,
  input  logic            par_stb,
  input  logic            stop_stb,
  input  logic            done,
  output logic [DMAX-1:0] data,
  output logic            valid,
  output logic            par_err,
  output logic            frm_err
);
  logic [DMAX-1:0] sh, sh_n, data_n;
  logic            acc, acc_n, pbad, pbad_n, sbad, sbad_n;
  logic            valid_n, perr_n, ferr_n;
  logic            bit_in;
  logic [LW-1:0]   shamt;

  assign bit_in = line ^ inv_data;
  assign shamt  = LW'(DMAX) - len;

  always_comb begin
    sh_n    = sh;
    acc_n   = acc;
    pbad_n  = pbad;
    sbad_n  = sbad;
    data_n  = data;
    perr_n  = par_err;
    ferr_n  = frm_err;
    valid_n = 1'b0;
    if (clr) begin
      sh_n   = '0;
      acc_n  = 1'b0;
      pbad_n = 1'b0;
      sbad_n = 1'b0;
    end
    if (data_stb) begin
      acc_n = acc ^ bit_in;
      if (msb_first) sh_n = {sh[DMAX-2:0], bit_in};
      else           sh_n = {bit_in, sh[DMAX-1:1]};
    end
    if (par_stb) begin
      unique case (par_mode)
        PAR_ODD:  pbad_n = ~(acc ^ bit_in);
        PAR_EVEN: pbad_n = acc ^ bit_in;
        PAR_ONE:  pbad_n = ~bit_in;
        PAR_ZERO: pbad_n = bit_in;
        default:  pbad_n = 1'b0;
      endcase
    end
    if (stop_stb && !line) sbad_n = 1'b1;
    if (done) begin
      valid_n = 1'b1;
      data_n  = msb_first ? sh : (sh >> shamt);
      perr_n  = pbad;
      ferr_n  = sbad | ~line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      acc     <= 1'b0;
      pbad    <= 1'b0;
      sbad    <= 1'b0;
      data    <= '0;
      valid   <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      sh      <= sh_n;
      acc     <= acc_n;
      pbad    <= pbad_n;
      sbad    <= sbad_n;
      data    <= data_n;
      valid   <= valid_n;
      par_err <= perr_n;
      frm_err <= ferr_n;
    end
  end
endmodule

// File: rtl/urx_top.sv
module urx_top
  import urx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int DMAX    = 9,
  parameter int DMIN    = 5,
  parameter int SYNC    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_16x,
  input  logic            rxd,
  input  logic [3:0]      cfg_data_bits,
  input  logic [2:0]      cfg_parity,
  input  logic [1:0]      cfg_stop,
  input  logic            cfg_msb_first,
  input  logic            cfg_inv_line,
  input  logic            cfg_inv_data,
  output logic [DMAX-1:0] rx_data,
  output logic            rx_valid,
  output logic            rx_parity_err,
  output logic            rx_frame_err
);
  localparam int LW = 4;
  localparam int CW = $clog2(2*OVS);

  logic [1:0]    rst_pipe;
  logic          rst_q_n;
  logic          line;
  logic [LW-1:0] len_eff;
  par_e          par_mode;
  stop_e         stop_sel;
  logic          par_en;
  state_e        fsm_state;
  logic [CW-1:0] fsm_cnt;
  logic          clr, data_stb, par_stb, stop_stb, done;

  // Reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  assign rst_q_n = rst_pipe[1];

  always_comb begin
    if (cfg_data_bits < LW'(DMIN))      len_eff = LW'(DMIN);
    else if (cfg_data_bits > LW'(DMAX)) len_eff = LW'(DMAX);
    else                                len_eff = cfg_data_bits;
  end

  assign par_mode = (cfg_parity > 3'd4) ? PAR_NONE : par_e'(cfg_parity);
  assign stop_sel = stop_e'(cfg_stop);
  assign par_en   = (par_mode != PAR_NONE);

  urx_line_sync #(.STAGES(SYNC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .din    (rxd),
    .invert (cfg_inv_line),
    .line   (line)
  );

  urx_frame_ctrl #(.OVS(OVS), .CW(CW), .LW(LW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tick     (tick_16x),
    .line     (line),
    .par_en   (par_en),
    .stop_sel (stop_sel),
    .last_idx (len_eff - 1'b1),
    .st       (fsm_state),
    .cnt      (fsm_cnt),
    .clr      (clr),
    .data_stb (data_stb),
    .par_stb  (par_stb),
    .stop_stb (stop_stb),
    .done     (done)
  );

  urx_assembler #(.DMAX(DMAX), .LW(LW)) u_asm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .line      (line),
    .inv_data  (cfg_inv_data),
    .msb_first (cfg_msb_first),
    .par_mode  (par_mode),
    .len       (len_eff),
    .clr       (clr),
    .data_stb  (data_stb),
    .par_stb   (par_stb),
    .stop_stb  (stop_stb),
    .done      (done),
    .data      (rx_data),
    .valid     (rx_valid),
    .par_err   (rx_parity_err),
    .frm_err   (rx_frame_err)
  );
endmodule

// File: rtl/urx_checker.sv
module urx_checker
  import urx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int DMAX = 9,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            line,
  input logic            valid,
  input logic [DMAX-1:0] data,
  input logic [3:0]      len,
  input state_e          st,
  input logic [CW-1:0]   cnt
);
  localparam int MID = OVS/2 - 1;

  // R11: strobe never lasts two clocks
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R2: bits above the selected length are zero when the strobe is high
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((data >> len) == '0));

  // R10: a line back at idle at the start confirmation point aborts the frame
  a_r10_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && tick && cnt == CW'(MID) && line) |=> (st == ST_IDLE));

  // R12: no state or counter motion without the tick
  a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(st) && $stable(cnt)));

  // R6: a strobe only follows the stop phase
  a_r6_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(st) == ST_STOP));
endmodule

bind urx_top urx_checker #(.OVS(OVS), .DMAX(DMAX), .CW(CW)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .tick  (tick_16x),
  .line  (line),
  .valid (rx_valid),
  .data  (rx_data),
  .len   (len_eff),
  .st    (fsm_state),
  .cnt   (fsm_cnt)
);

// File: tb/tb_urx_top.sv
`timescale 1ns/1ps
module tb_urx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic [2:0] cfg_par = 3'd0;
  logic [1:0] cfg_stop = 2'd1;
  logic       cfg_msb = 1'b0, cfg_invl = 1'b0, cfg_invd = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid, rx_pe, rx_fe;

  int checks = 0, fails = 0, cyc = 0;
  int vcount = 0, vcyc = 0, dbl = 0;
  logic [8:0] vdata;
  logic vpe, vfe, last_v = 1'b0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  urx_top dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick), .rxd(rxd),
    .cfg_data_bits(cfg_len), .cfg_parity(cfg_par), .cfg_stop(cfg_stop),
    .cfg_msb_first(cfg_msb), .cfg_inv_line(cfg_invl), .cfg_inv_data(cfg_invd),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_pe), .rx_frame_err(rx_fe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount <= vcount + 1;
      vcyc   <= cyc;
      vdata  <= rx_data;
      vpe    <= rx_pe;
      vfe    <= rx_fe;
      if (last_v) dbl <= dbl + 1;
    end
    last_v <= rx_valid;
  end

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // data(9) len(4) par(3) stop(2) msb invl invd badp bads
  localparam logic [22:0] VEC [0:13] = '{
    {9'h0A5, 4'd8, 3'd0, 2'd1, 5'b00000},
    {9'h015, 4'd5, 3'd0, 2'd1, 5'b00000},
    {9'h1A3, 4'd9, 3'd0, 2'd3, 5'b00000},
    {9'h0A5, 4'd8, 3'd0, 2'd1, 5'b10000},
    {9'h05A, 4'd7, 3'd1, 2'd1, 5'b00000},
    {9'h05A, 4'd7, 3'd2, 2'd1, 5'b00010},
    {9'h03C, 4'd8, 3'd3, 2'd1, 5'b00000},
    {9'h03C, 4'd8, 3'd4, 2'd1, 5'b00010},
    {9'h066, 4'd8, 3'd0, 2'd0, 5'b00000},
    {9'h066, 4'd8, 3'd2, 2'd2, 5'b00000},
    {9'h0C3, 4'd8, 3'd0, 2'd1, 5'b00001},
    {9'h04E, 4'd8, 3'd1, 2'd1, 5'b01000},
    {9'h04E, 4'd8, 3'd1, 2'd3, 5'b00100},
    {9'h009, 4'd6, 3'd2, 2'd1, 5'b11110}
  };

  function automatic string tag(int i);
    case (i)
      0, 1, 2: return "R2";
      3:       return "R3";
      4, 5:    return "R4";
      6, 7:    return "R5";
      8, 9:    return "R6";
      10:      return "R7";
      11:      return "R8";
      12:      return "R9";
      default: return "R3/R9";
    endcase
  endfunction

  task automatic put(bit lvl, int n);
    @(negedge clk) rxd = lvl ^ cfg_invl;
    repeat (n - 1) @(negedge clk);
  endtask

  // Drives one frame; returns the cycle stamp of the start edge
  task automatic send(input logic [8:0] d, input int len, input int par,
                      input int stp, input bit badp, input bit bads,
                      output int c0);
    bit pb;
    @(negedge clk);
    rxd = 1'b0 ^ cfg_invl;
    c0  = cyc;
    repeat (15) @(negedge clk);
    for (int i = 0; i < len; i++)
      put(cfg_msb ? d[len-1-i] ^ cfg_invd : d[i] ^ cfg_invd, 16);
    if (par >= 1 && par <= 4) begin
      case (par)
        1: pb = ~(^(d & 9'((1 << len) - 1)));
        2: pb = ^(d & 9'((1 << len) - 1));
        3: pb = 1'b1;
        default: pb = 1'b0;
      endcase
      put(pb ^ badp ^ cfg_invd, 16);
    end
    put(~bads, (stp == 0) ? 8 : (stp == 1) ? 16 : (stp == 2) ? 24 : 32);
    put(1'b1, 24);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    report();
  end

  initial begin
    int c0, n0, lat, nb, s;
    logic [8:0] d, mask;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", rx_valid === 1'b0, rx_valid, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 outputs after reset", {rx_valid, rx_pe, rx_fe, rx_data} === 12'h0,
        {rx_valid, rx_pe, rx_fe, rx_data}, 0);

    for (int i = 0; i < 14; i++) begin
      logic [22:0] v;
      v = VEC[i];
      @(negedge clk);
      cfg_len  = v[13:10];
      cfg_par  = v[9:7];
      cfg_stop = v[6:5];
      cfg_msb  = v[4];
      cfg_invl = v[3];
      cfg_invd = v[2];
      rxd      = 1'b1 ^ v[3];
      repeat (40) @(negedge clk);
      n0 = vcount;
      d  = v[22:14];
      send(d, int'(v[13:10]), int'(v[9:7]), int'(v[6:5]), v[1], v[0], c0);
      mask = 9'((1 << int'(v[13:10])) - 1);
      nb = int'(v[13:10]) + ((v[9:7] != 0) ? 1 : 0);
      case (v[6:5])
        2'd0: s = 3;
        2'd1: s = 7;
        2'd2: s = 19;
        default: s = 23;
      endcase
      lat = 20 + 16 * nb + s;
      chk({tag(i), " R11 one strobe"}, vcount == n0 + 1, vcount - n0, 1);
      chk({tag(i), " data"}, vdata == (d & mask), vdata, d & mask);
      chk({tag(i), " R4/R5 parity flag"}, vpe == v[1], vpe, v[1]);
      chk({tag(i), " R7 frame flag"}, vfe == v[0], vfe, v[0]);
      chk({tag(i), " R6 latency"}, (vcyc - c0) == lat, vcyc - c0, lat);
    end

    // R10: short low pulse rejected
    @(negedge clk);
    cfg_len = 4'd8; cfg_par = 3'd0; cfg_stop = 2'd1;
    cfg_msb = 1'b0; cfg_invl = 1'b0; cfg_invd = 1'b0; rxd = 1'b1;
    repeat (40) @(negedge clk);
    n0 = vcount;
    put(1'b0, 4);
    put(1'b1, 200);
    chk("R10 glitch rejected", vcount == n0, vcount - n0, 0);
    send(9'h0C5, 8, 0, 1, 1'b0, 1'b0, c0);
    chk("R10 frame after glitch", vcount == n0 + 1 && vdata == 9'h0C5, vdata, 9'h0C5);

    // R12: no tick, no frame
    @(negedge clk) tick = 1'b0;
    n0 = vcount;
    send(9'h0F0, 8, 0, 1, 1'b0, 1'b0, c0);
    chk("R12 frozen without tick", vcount == n0, vcount - n0, 0);
    @(negedge clk) tick = 1'b1;
    repeat (40) @(negedge clk);
    send(9'h011, 8, 0, 1, 1'b0, 1'b0, c0);
    chk("R12 resumes with tick", vcount == n0 + 1 && vdata == 9'h011, vdata, 9'h011);

    // R2: length code above 9 acts as 9
    @(negedge clk) cfg_len = 4'd12;
    repeat (20) @(negedge clk);
    n0 = vcount;
    send(9'h155, 9, 0, 1, 1'b0, 1'b0, c0);
    chk("R2 clamp to nine", vcount == n0 + 1 && vdata == 9'h155, vdata, 9'h155);

    // R1: reset mid-frame clears outputs
    @(negedge clk) cfg_len = 4'd8;
    @(negedge clk) rxd = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame reset", {rx_valid, rx_data} === 10'h0, {rx_valid, rx_data}, 0);
    rxd = 1'b1;
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    n0 = vcount;
    send(9'h03A, 8, 0, 1, 1'b0, 1'b0, c0);
    chk("R1 frame after reset", vcount == n0 + 1 && vdata == 9'h03A, vdata, 9'h03A);

    chk("R11 no double strobe", dbl == 0, dbl, 0);
    report();
  end
endmodule